// File: doc/BRIEF.md
# Grouped 4x4 Cross-Lane Register Transpose

This block keeps a bank of eight vector registers. Each register is 32 lanes wide, and each lane holds an opaque data word whose width is a parameter (32 bits by default). On a single strobe the block shuffles data across lanes and registers in one clock cycle. The bank splits into two groups that behave the same way and never exchange data: registers 0 to 3, and registers 4 to 7. Inside a register the 32 lanes form a grid of 4 rows by 8 columns. For each column, the four registers of a group together hold a 4x4 tile, with the register index as one axis and the row as the other. The strobe transposes every such tile at once.

Software fills and drains the bank through a whole-register write port and a combinational read port. A 32-bit lane mask gates the shuffle: a lane whose mask bit is clear keeps its value. A 4-bit destination field travels with the strobe and decides, together with a configuration flag, whether the strobe does anything. The shuffle moves data and does no arithmetic. A typical use is a pair of strobes around a row-wise computation: the first brings each tile into a register-per-column layout, and the second returns it to the original layout.

Top module: `lane_xpose_bank`

## Requirements
- R1: Lane index l of a register maps to row l/8 and column l%8. Lane l of a register sits at bits [l*DW +: DW] of the write and read data buses.
- R2: When the strobe fires, every pair i > j in a group and every column c exchange two values: register base+i lane j*8+c and register base+j lane i*8+c. Diagonal lanes (lane i*8+c of register base+i) do not change.
- R3: Registers 0 to 3 and registers 4 to 7 are transposed independently. No value crosses from one group to the other.
- R4: A lane updates on a firing strobe only when its bit in the lane mask is set. A lane whose bit is clear keeps its old value even when its partner lane updates.
- R5: The strobe fires only when the destination field is below 12 or the configuration flag is high. Otherwise the bank is left unchanged.
- R6: Results of a strobe can be read in the cycle after the strobe's clock edge. A strobe is accepted in every cycle, including consecutive cycles.
- R7: Two firing strobes with every lane enabled restore the original bank contents.
- R8: Every exchanged value is taken from the bank as it stood before the strobe's edge, so the whole bank updates at the same time.
- R9: A register write in the same cycle as a firing strobe is discarded. A write that comes with a non-firing strobe takes effect.
- R10: A write stores the whole write data bus into the selected register at the clock edge. The read data shows the selected register's current contents with no cycle of delay.
- R11: After reset every lane of every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write request |
| wr_sel | input | 3 | Register picked for the write |
| wr_data | input | 32*DW | Write data, lane l at bits l*DW |
| rd_sel | input | 3 | Register picked for the read |
| rd_data | output | 32*DW | Read data of the register picked by rd_sel |
| lane_en | input | 32 | Per-lane update mask for the transpose |
| xp_go | input | 1 | Transpose strobe |
| xp_dst | input | 4 | Destination field that travels with the strobe |
| xp_force | input | 1 | Configuration flag that lets the strobe fire regardless of xp_dst |

## Verification
If a tile's source index is wrong, the fault shows on the read port in the cycle after a single all-enabled strobe. A wrong mask bit or a missed gate shows up the same way, as a lane that changed when it should have held, or held when it should have changed. Wrong snapshot ordering only shows when both lanes of a pair are enabled. A wrong lane pairing can hide behind the second strobe of a pair, so the bench reads the bank after every single strobe, not only after round trips. Errors in the group boundary appear when the other group holds distinct contents: they show as foreign values in a group that was left out of the stimulus.

// File: rtl/lane_xpose_bank.sv
module lane_xpose_bank #(
  parameter int DW        = 32,
  parameter int GRP       = 4,
  parameter int COLS      = 8,
  parameter int NGRP      = 2,
  parameter int DSTW      = 4,
  parameter int DST_LIMIT = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(GRP*NGRP)-1:0] wr_sel,
  input  logic [GRP*COLS*DW-1:0]      wr_data,
  input  logic [$clog2(GRP*NGRP)-1:0] rd_sel,
  output logic [GRP*COLS*DW-1:0]      rd_data,
  input  logic [GRP*COLS-1:0]         lane_en,
  input  logic                        xp_go,
  input  logic [DSTW-1:0]             xp_dst,
  input  logic                        xp_force
);
  localparam int NREG  = GRP * NGRP;
  localparam int LANES = GRP * COLS;
  localparam int RW    = $clog2(NREG);
  localparam int REGW  = LANES * DW;

  logic [NREG*REGW-1:0] bank_q;
  logic [NREG*REGW-1:0] bank_d;
  logic [REGW-1:0]      reg_view [NREG];

  wire xp_fire = xp_go && ((int'(xp_dst) < DST_LIMIT) || xp_force);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam int BASE = (r / GRP) * GRP;
    localparam int IDX  = r % GRP;
    wire wr_hit = wr_en && (wr_sel == RW'(r));
    assign reg_view[r] = bank_q[r*REGW +: REGW];
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int ROW   = l / COLS;
      localparam int COL   = l % COLS;
      localparam int SRC_R = BASE + ROW;
      localparam int SRC_L = IDX * COLS + COL;
      wire [DW-1:0] cur  = bank_q[(r*LANES+l)*DW +: DW];
      wire [DW-1:0] swp  = bank_q[(SRC_R*LANES+SRC_L)*DW +: DW];
      wire [DW-1:0] wval = wr_data[l*DW +: DW];
      assign bank_d[(r*LANES+l)*DW +: DW] =
        xp_fire ? (lane_en[l] ? swp : cur) :
        wr_hit  ? wval : cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  assign rd_data = reg_view[rd_sel];
endmodule

// File: rtl/lane_xpose_bank_chk.sv
module lane_xpose_bank_chk #(
  parameter int DW        = 32,
  parameter int GRP       = 4,
  parameter int COLS      = 8,
  parameter int NGRP      = 2,
  parameter int DSTW      = 4,
  parameter int DST_LIMIT = 12
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             wr_en,
  input logic [$clog2(GRP*NGRP)-1:0]      wr_sel,
  input logic [GRP*COLS*DW-1:0]           wr_data,
  input logic [GRP*COLS-1:0]              lane_en,
  input logic                             xp_go,
  input logic [DSTW-1:0]                  xp_dst,
  input logic                             xp_force,
  input logic [GRP*NGRP*GRP*COLS*DW-1:0]  bank_q
);
  localparam int NREG  = GRP * NGRP;
  localparam int LANES = GRP * COLS;
  localparam int RW    = $clog2(NREG);
  localparam int REGW  = LANES * DW;

  wire go_ok   = xp_go && ((int'(xp_dst) < DST_LIMIT) || xp_force);
  wire go_dead = xp_go && !((int'(xp_dst) < DST_LIMIT) || xp_force);

  a_r5_gated_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (go_dead && !wr_en) |=> $stable(bank_q));

  for (genvar r = 0; r < NREG; r++) begin : g_r
    localparam int BASE = (r / GRP) * GRP;
    localparam int IDX  = r % GRP;

    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !go_ok && wr_sel == RW'(r)) |=> bank_q[r*REGW +: REGW] == $past(wr_data));

    for (genvar l = 0; l < LANES; l++) begin : g_l
      localparam int ROW   = l / COLS;
      localparam int SRC_R = BASE + ROW;
      localparam int SRC_L = IDX * COLS + (l % COLS);

      a_r2_pair_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (go_ok && lane_en[l]) |=>
          bank_q[(r*LANES+l)*DW +: DW] == $past(bank_q[(SRC_R*LANES+SRC_L)*DW +: DW]));

      a_r4_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (go_ok && !lane_en[l]) |=> $stable(bank_q[(r*LANES+l)*DW +: DW]));

      if (ROW == IDX) begin : g_diag
        a_r2_diag_fixed: assert property (@(posedge clk) disable iff (!rst_n)
          go_ok |=> $stable(bank_q[(r*LANES+l)*DW +: DW]));
      end
    end
  end
endmodule

bind lane_xpose_bank lane_xpose_bank_chk #(
  .DW(DW), .GRP(GRP), .COLS(COLS), .NGRP(NGRP), .DSTW(DSTW), .DST_LIMIT(DST_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .lane_en(lane_en), .xp_go(xp_go), .xp_dst(xp_dst), .xp_force(xp_force),
  .bank_q(bank_q)
);

// File: tb/tb_lane_xpose_bank.sv
`timescale 1ns/1ps
module tb_lane_xpose_bank;
  localparam int DW = 32;
  localparam int LANES = 32;
  localparam int NREG = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [LANES*DW-1:0] wr_data = '0;
  logic [2:0] rd_sel = 0;
  logic [LANES*DW-1:0] rd_data;
  logic [LANES-1:0] lane_en = '0;
  logic xp_go = 0;
  logic [3:0] xp_dst = 0;
  logic xp_force = 0;

  int checks = 0;
  int errors = 0;
  bit [DW-1:0] mdl [NREG][LANES];
  bit [DW-1:0] keep [NREG][LANES];

  always #2.5 clk = ~clk;

  lane_xpose_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .lane_en(lane_en), .xp_go(xp_go),
    .xp_dst(xp_dst), .xp_force(xp_force)
  );

  function automatic bit fires(bit [3:0] d, bit f);
    return (d < 12) || f;
  endfunction

  task automatic model_xp(bit [LANES-1:0] m);
    bit [DW-1:0] snap [NREG][LANES];
    snap = mdl;
    for (int r = 0; r < NREG; r++)
      for (int l = 0; l < LANES; l++)
        if (m[l]) mdl[r][l] = snap[(r/4)*4 + l/8][(r%4)*8 + l%8];
  endtask

  function automatic logic [LANES*DW-1:0] rnd_reg();
    logic [LANES*DW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*DW +: DW] = $urandom;
    return v;
  endfunction

  task automatic check_all(string tag);
    for (int r = 0; r < NREG; r++) begin
      logic [LANES*DW-1:0] exp_v;
      for (int l = 0; l < LANES; l++) exp_v[l*DW +: DW] = mdl[r][l];
      rd_sel = 3'(r);
      #0.3;
      checks++;
      if (rd_data !== exp_v) begin
        errors++;
        $display("FAIL %s reg %0d actual %h expected %h", tag, r, rd_data, exp_v);
      end
    end
  endtask

  task automatic idle();
    wr_en = 0; xp_go = 0;
  endtask

  task automatic op(bit w, int ws, logic [LANES*DW-1:0] wd,
                    bit g, bit [3:0] d, bit f, bit [LANES-1:0] m);
    @(negedge clk);
    wr_en = w; wr_sel = 3'(ws); wr_data = wd;
    xp_go = g; xp_dst = d; xp_force = f; lane_en = m;
    if (g && fires(d, f)) model_xp(m);
    else if (w) for (int l = 0; l < LANES; l++) mdl[ws][l] = wd[l*DW +: DW];
  endtask

  task automatic settle();
    @(posedge clk); #1; idle();
  endtask

  task automatic fill_random();
    for (int r = 0; r < NREG; r++) begin
      op(1, r, rnd_reg(), 0, 0, 0, '0); settle();
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int r = 0; r < NREG; r++) for (int l = 0; l < LANES; l++) mdl[r][l] = '0;
    repeat (3) @(negedge clk);
    check_all("R11 reset zero");
    rst_n = 1;
    @(negedge clk);

    // R10 R1: writes with lane-indexed patterns
    for (int r = 0; r < NREG; r++) begin
      logic [LANES*DW-1:0] v;
      for (int l = 0; l < LANES; l++) v[l*DW +: DW] = DW'((r << 8) | l);
      op(1, r, v, 0, 0, 0, '0); settle();
    end
    check_all("R10 R1 write/read");

    // R2 R3 R8: single full transpose of known pattern
    op(0, 0, '0, 1, 0, 0, '1); settle();
    check_all("R2 R3 R8 full transpose");
    // R7: second transpose restores
    op(0, 0, '0, 1, 0, 0, '1); settle();
    check_all("R7 round trip");

    // R3: only group 0 loaded, group 1 zero
    for (int r = 0; r < NREG; r++) begin
      op(1, r, (r < 4) ? rnd_reg() : '0, 0, 0, 0, '0); settle();
    end
    op(0, 0, '0, 1, 3, 0, '1); settle();
    check_all("R3 group isolation");

    // R4: partial masks
    fill_random();
    op(0, 0, '0, 1, 0, 0, 32'h0000_00ff); settle();
    check_all("R4 mask row0");
    op(0, 0, '0, 1, 0, 0, 32'h5a5a_a5a5); settle();
    check_all("R4 mask mixed");
    op(0, 0, '0, 1, 0, 0, '0); settle();
    check_all("R4 mask none");

    // R5: gate
    op(0, 0, '0, 1, 12, 0, '1); settle();
    check_all("R5 dst 12 blocked");
    op(0, 0, '0, 1, 15, 0, '1); settle();
    check_all("R5 dst 15 blocked");
    op(0, 0, '0, 1, 11, 0, '1); settle();
    check_all("R5 dst 11 fires");
    op(0, 0, '0, 1, 15, 1, '1); settle();
    check_all("R5 flag forces");

    // R6: back-to-back strobes
    op(0, 0, '0, 1, 0, 0, '1);
    op(0, 0, '0, 1, 0, 0, 32'hf0f0_0f0f);
    op(0, 0, '0, 1, 5, 0, '1);
    settle();
    check_all("R6 back to back");

    // R9: write with firing vs blocked strobe
    op(1, 2, rnd_reg(), 1, 0, 0, '1); settle();
    check_all("R9 write dropped on fire");
    op(1, 6, rnd_reg(), 1, 13, 0, '1); settle();
    check_all("R9 write with dead strobe");

    // random mix
    for (int k = 0; k < 300; k++) begin
      bit w = 1'($urandom);
      bit g = 1'($urandom);
      bit [3:0] d = 4'($urandom);
      bit f = ($urandom % 4) == 0;
      bit [LANES-1:0] m = ($urandom % 3 == 0) ? '1 : LANES'($urandom);
      op(w, int'($urandom % NREG), rnd_reg(), g, d, f, m);
      settle();
      if (k % 3 == 0) check_all("R2 R4 R5 R9 random");
    end
    check_all("R2 R4 R5 R9 random end");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule